// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a two-bank single-data-rate SDRAM from power-on to a usable state on the controller side. From reset it holds the clock-enable and data-mask pins high and keeps the command bus idle. Once a programmable settle time has passed, it issues a precharge of every bank, loads the mode register, and runs a train of auto-refresh commands. It leaves the minimum command-to-command gaps between these steps. When the last gap has elapsed it raises a ready flag, which hands the memory over to the normal read, write and refresh logic.

All delays are given in nanoseconds and converted to clock counts at elaboration, rounding up. The mode word comes from parameters: CAS latency, burst length and burst order. A parameter picks whether the mode load comes before or after the refresh train. The asynchronous reset is released through a synchronizer, so the sequence begins a fixed number of edges after reset is removed.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is low, and for the whole settle period, the command pins show an idle cycle: cs_n low with ras_n, cas_n and we_n high. ready is low. Lowering rst_n forces this state at once, without waiting for a clock edge.
- R2: The first command appears exactly SYNC_STAGES + S clock edges after the first edge that follows reset release. S = max(1, ceil(SETTLE_NS*1000/CLK_PS)), and the default SETTLE_NS is 200000.
- R3: The first command is a precharge of all banks: cs_n, ras_n and we_n low, cas_n high, addr bit 10 high and every other addr bit low.
- R4: The mode load is encoded as cs_n, ras_n, cas_n and we_n all low. addr carries the opcode: bits 2:0 hold log2 of the burst length, bit 3 is 1 for interleaved order, bits 6:4 hold the CAS latency, and all higher bits are 0.
- R5: Exactly REFRESH_COUNT auto-refresh commands are issued, where REFRESH_COUNT is at least 8. Each one is cs_n, ras_n and cas_n low with we_n high.
- R6: With MODE_FIRST=1 the order is precharge, mode load, then the refreshes. With MODE_FIRST=0 it is precharge, the refreshes, then the mode load.
- R7: Each command follows the previous one after exactly max(2, ceil(T*1000/CLK_PS)) cycles. T is TRP_NS after a precharge, TMRD_NS after a mode load and TRC_NS after a refresh. Every cycle in between is idle.
- R8: ready rises exactly the R7 gap of the final command after that command. It then stays high until reset, and no further command is issued.
- R9: cke and dqm are high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | SDRAM clock enable, held high |
| dqm | output | 1 | SDRAM data mask, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus: precharge-all flag or mode opcode |
| ready | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench builds two instances side by side with a 5 ns clock, and shrinks the settle time to tens of nanoseconds so that the full sequence finishes in a few hundred cycles. One instance loads the mode first, uses 8 refreshes, exact-multiple and rounded-up gaps, and a sequential burst of 4. The other puts the mode load last, uses 9 refreshes, an interleaved burst of 8, and a mode-load time short enough to hit the two-cycle floor. Together they cover both orderings, both rounding cases and the floor clamp. The bench records every non-idle cycle, then compares the command kinds, addresses and cycle stamps against values it computes from the timing parameters.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_PALL = 2'd1,
    CMD_MODE = 2'd2,
    CMD_AREF = 2'd3
  } boot_cmd_e;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_CMD    = 2'd1,
    ST_GAP    = 2'd2,
    ST_DONE   = 2'd3
  } seq_st_e;

  // Nanoseconds to clock cycles, rounded up, never below floor_v.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned ps,
                                            int unsigned floor_v);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * 64'd1000;
    cyc  = (prod + longint'(ps) - 64'd1) / longint'(ps);
    if (cyc < longint'(floor_v)) return floor_v;
    return int'(cyc);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[0] <= 1'b0;
          else         sync_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
  parameter int CW      = 16,
  parameter int RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/boot_step_plan.sv
module boot_step_plan
  import sdram_boot_pkg::*;
#(
  parameter int SW            = 4,
  parameter int CW            = 16,
  parameter int REFRESH_COUNT = 8,
  parameter bit MODE_FIRST    = 1'b1,
  parameter int TRP_CYC       = 2,
  parameter int TMRD_CYC      = 2,
  parameter int TRC_CYC       = 2
) (
  input  logic [SW-1:0] step,
  output boot_cmd_e     kind,
  output logic [CW-1:0] gap
);
  localparam int LAST = REFRESH_COUNT + 1;

  generate
    if (MODE_FIRST) begin : g_mode_first
      always_comb begin
        if (step == '0)            kind = CMD_PALL;
        else if (step == SW'(1))   kind = CMD_MODE;
        else                       kind = CMD_AREF;
      end
    end else begin : g_mode_last
      always_comb begin
        if (step == '0)            kind = CMD_PALL;
        else if (step == SW'(LAST)) kind = CMD_MODE;
        else                       kind = CMD_AREF;
      end
    end
  endgenerate

  always_comb begin
    unique case (kind)
      CMD_PALL: gap = CW'(TRP_CYC);
      CMD_MODE: gap = CW'(TMRD_CYC);
      CMD_AREF: gap = CW'(TRC_CYC);
      default:  gap = CW'(2);
    endcase
  end
endmodule

// File: rtl/boot_cmd_enc.sv
module boot_cmd_enc
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W           = 12,
  parameter int AP_BIT           = 10,
  parameter int CAS_LAT          = 3,
  parameter int BURST_LEN        = 4,
  parameter bit BURST_INTERLEAVE = 1'b0
) (
  input  boot_cmd_e         kind,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  localparam int BL_CODE = $clog2(BURST_LEN);
  localparam int OPC_I   = ((CAS_LAT & 7) << 4) | (int'(BURST_INTERLEAVE) << 3) |
                           (BL_CODE & 7);
  localparam logic [ADDR_W-1:0] OPCODE  = ADDR_W'(OPC_I);
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    unique case (kind)
      CMD_PALL: begin
        ras_n = 1'b0;
        we_n  = 1'b0;
        addr  = AP_MASK;
      end
      CMD_MODE: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        addr  = OPCODE;
      end
      CMD_AREF: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int CLK_PS           = 5000,
  parameter int SETTLE_NS        = 200000,
  parameter int TRP_NS           = 20,
  parameter int TMRD_NS          = 10,
  parameter int TRC_NS           = 70,
  parameter int REFRESH_COUNT    = 8,
  parameter bit MODE_FIRST       = 1'b1,
  parameter int CAS_LAT          = 3,
  parameter int BURST_LEN        = 4,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int ADDR_W           = 12,
  parameter int SYNC_STAGES      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam int AP_BIT     = 10;
  localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PS, 1);
  localparam int TRP_CYC    = ns_to_cyc(TRP_NS,    CLK_PS, 2);
  localparam int TMRD_CYC   = ns_to_cyc(TMRD_NS,   CLK_PS, 2);
  localparam int TRC_CYC    = ns_to_cyc(TRC_NS,    CLK_PS, 2);
  localparam int MAX_CYC    = max2(max2(SETTLE_CYC, TRP_CYC), max2(TMRD_CYC, TRC_CYC));
  localparam int CW         = $clog2(MAX_CYC + 1) + 1;
  localparam int NSTEP      = REFRESH_COUNT + 2;
  localparam int SW         = $clog2(NSTEP + 1);
  localparam int LAST_STEP  = NSTEP - 1;
  localparam int RW         = $clog2(REFRESH_COUNT + 1) + 1;

  logic          rst_i_n;
  seq_st_e       st_q, st_d;
  logic [SW-1:0] step_q, step_d;
  logic          step_en;
  logic          tmr_load;
  logic          tmr_zero;
  logic [CW-1:0] gap_cyc;
  logic [CW-1:0] tmr_val;
  boot_cmd_e     plan_kind;
  boot_cmd_e     out_kind;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i_n)
  );

  boot_step_plan #(
    .SW            (SW),
    .CW            (CW),
    .REFRESH_COUNT (REFRESH_COUNT),
    .MODE_FIRST    (MODE_FIRST),
    .TRP_CYC       (TRP_CYC),
    .TMRD_CYC      (TMRD_CYC),
    .TRC_CYC       (TRC_CYC)
  ) u_plan (
    .step (step_q),
    .kind (plan_kind),
    .gap  (gap_cyc)
  );

  assign tmr_val = gap_cyc - CW'(2);

  boot_gap_timer #(
    .CW      (CW),
    .RST_VAL (SETTLE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // Next-state process
  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    step_en  = 1'b0;
    tmr_load = 1'b0;
    unique case (st_q)
      ST_SETTLE: if (tmr_zero) st_d = ST_CMD;
      ST_CMD: begin
        tmr_load = 1'b1;
        st_d     = ST_GAP;
      end
      ST_GAP: begin
        if (tmr_zero) begin
          if (step_q == SW'(LAST_STEP)) begin
            st_d = ST_DONE;
          end else begin
            step_en = 1'b1;
            step_d  = step_q + SW'(1);
            st_d    = ST_CMD;
          end
        end
      end
      ST_DONE: ;
      default: st_d = ST_SETTLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_SETTLE;
      step_q <= '0;
    end else begin
      st_q <= st_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign out_kind = (st_q == ST_CMD) ? plan_kind : CMD_IDLE;

  boot_cmd_enc #(
    .ADDR_W           (ADDR_W),
    .AP_BIT           (AP_BIT),
    .CAS_LAT          (CAS_LAT),
    .BURST_LEN        (BURST_LEN),
    .BURST_INTERLEAVE (BURST_INTERLEAVE)
  ) u_enc (
    .kind  (out_kind),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr)
  );

  assign cke   = 1'b1;
  assign dqm   = 1'b1;
  assign ready = (st_q == ST_DONE);

  // Assertion support: refreshes seen on the pins
  logic [RW-1:0] ref_seen_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ref_seen_q <= '0;
    else if (!cs_n && !ras_n && !cas_n && we_n) ref_seen_q <= ref_seen_q + RW'(1);
  end

  a_r1_settle_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_SETTLE) |-> (!cs_n && ras_n && cas_n && we_n && !ready));

  a_r3_first_is_precharge: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_CMD && step_q == '0) |-> (!ras_n && cas_n && !we_n && addr[AP_BIT]));

  a_r7_idle_after_cmd: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_CMD) |=> (ras_n && cas_n && we_n));

  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    ready |=> ready);

  a_r8_quiet_after_ready: assert property (@(posedge clk) disable iff (!rst_i_n)
    ready |-> (ras_n && cas_n && we_n));

  a_r5_refresh_total: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ready) |-> (ref_seen_q == RW'(REFRESH_COUNT)));

endmodule

// File: tb/sdram_boot_seq_bench.sv
module sdram_boot_seq_bench;
  localparam int CLK_PS = 5000;
  localparam int NI     = 2;
  localparam int MAXEV  = 32;

  logic clk;
  logic rst_n;
  logic [NI-1:0] cke_w, dqm_w, cs_w, ras_w, cas_w, we_w, rdy_w;
  logic [NI-1:0][11:0] addr_w;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sdram_boot_seq #(
    .CLK_PS(CLK_PS), .SETTLE_NS(100), .TRP_NS(18), .TMRD_NS(7), .TRC_NS(65),
    .REFRESH_COUNT(8), .MODE_FIRST(1'b1), .CAS_LAT(3), .BURST_LEN(4),
    .BURST_INTERLEAVE(1'b0)
  ) u_sdram_boot_seq (
    .clk(clk), .rst_n(rst_n), .cke(cke_w[0]), .dqm(dqm_w[0]), .cs_n(cs_w[0]),
    .ras_n(ras_w[0]), .cas_n(cas_w[0]), .we_n(we_w[0]), .addr(addr_w[0]),
    .ready(rdy_w[0])
  );

  sdram_boot_seq #(
    .CLK_PS(CLK_PS), .SETTLE_NS(72), .TRP_NS(11), .TMRD_NS(3), .TRC_NS(61),
    .REFRESH_COUNT(9), .MODE_FIRST(1'b0), .CAS_LAT(2), .BURST_LEN(8),
    .BURST_INTERLEAVE(1'b1)
  ) u_sdram_boot_seq_swap (
    .clk(clk), .rst_n(rst_n), .cke(cke_w[1]), .dqm(dqm_w[1]), .cs_n(cs_w[1]),
    .ras_n(ras_w[1]), .cas_n(cas_w[1]), .we_n(we_w[1]), .addr(addr_w[1]),
    .ready(rdy_w[1])
  );

  // Bench-side configuration mirror
  int p_settle[NI] = '{100, 72};
  int p_trp[NI]    = '{18, 11};
  int p_tmrd[NI]   = '{7, 3};
  int p_trc[NI]    = '{65, 61};
  int p_rc[NI]     = '{8, 9};
  int p_mf[NI]     = '{1, 0};
  int p_opc[NI]    = '{(3 << 4) | (0 << 3) | 2, (2 << 4) | (1 << 3) | 3};

  int vectors, miscompares;
  int cyc;
  int n_ev[NI];
  int ev_cyc[NI][MAXEV];
  int ev_kind[NI][MAXEV];
  logic [11:0] ev_addr[NI][MAXEV];
  int rdy_cyc[NI];
  int pin_bad[NI];
  int cmd_after_rdy[NI];
  int rdy_drop[NI];

  // kinds: 1 precharge, 2 mode load, 3 refresh, 9 anything else
  function automatic int to_cyc(int ns, int floor_v);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < floor_v) ? floor_v : c;
  endfunction

  function automatic int gap_of(int i, int kind);
    if (kind == 1) return to_cyc(p_trp[i], 2);
    if (kind == 2) return to_cyc(p_tmrd[i], 2);
    return to_cyc(p_trc[i], 2);
  endfunction

  function automatic int exp_kind(int i, int j);
    if (j == 0) return 1;
    if (p_mf[i] != 0) return (j == 1) ? 2 : 3;
    return (j == p_rc[i] + 1) ? 2 : 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    else       cyc <= 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < NI; i++) begin
      if (!cke_w[i] || !dqm_w[i]) pin_bad[i]++;
      if (rst_n) begin
        if (rdy_cyc[i] >= 0 && !rdy_w[i]) rdy_drop[i]++;
        if (rdy_w[i] && rdy_cyc[i] < 0) rdy_cyc[i] = cyc;
        if (!cs_w[i] && !(ras_w[i] && cas_w[i] && we_w[i])) begin
          if (rdy_cyc[i] >= 0) cmd_after_rdy[i]++;
          if (n_ev[i] < MAXEV) begin
            ev_cyc[i][n_ev[i]]  = cyc;
            ev_addr[i][n_ev[i]] = addr_w[i];
            if (!ras_w[i] && cas_w[i] && !we_w[i])       ev_kind[i][n_ev[i]] = 1;
            else if (!ras_w[i] && !cas_w[i] && !we_w[i]) ev_kind[i][n_ev[i]] = 2;
            else if (!ras_w[i] && !cas_w[i] && we_w[i])  ev_kind[i][n_ev[i]] = 3;
            else                                         ev_kind[i][n_ev[i]] = 9;
          end
          n_ev[i]++;
        end
      end
    end
  end

  task automatic verify(input int i);
    int exp_c;
    int nref;
    int lim;
    check(n_ev[i] == p_rc[i] + 2, "R5 command total", n_ev[i], p_rc[i] + 2);
    exp_c = to_cyc(p_settle[i], 1) + 2;
    nref  = 0;
    lim   = (n_ev[i] < MAXEV) ? n_ev[i] : MAXEV;
    for (int j = 0; j < lim; j++) begin
      if (j == 0)
        check(ev_cyc[i][0] == exp_c, "R2 settle length", ev_cyc[i][0], exp_c);
      else
        check(ev_cyc[i][j] == exp_c, "R7 command spacing", ev_cyc[i][j], exp_c);
      check(ev_kind[i][j] == exp_kind(i, j), "R6 command order", ev_kind[i][j],
            exp_kind(i, j));
      if (ev_kind[i][j] == 1)
        check(ev_addr[i][j] == 12'h400, "R3 precharge-all address",
              int'(ev_addr[i][j]), 'h400);
      if (ev_kind[i][j] == 2)
        check(ev_addr[i][j] == 12'(p_opc[i]), "R4 mode opcode",
              int'(ev_addr[i][j]), p_opc[i]);
      if (ev_kind[i][j] == 3) nref++;
      exp_c = ev_cyc[i][j] + gap_of(i, ev_kind[i][j]);
    end
    check(nref == p_rc[i], "R5 refresh count", nref, p_rc[i]);
    check(rdy_cyc[i] == exp_c, "R8 ready timing", rdy_cyc[i], exp_c);
    check(rdy_drop[i] == 0, "R8 ready sticky", rdy_drop[i], 0);
    check(cmd_after_rdy[i] == 0, "R8 no command after ready", cmd_after_rdy[i], 0);
    check(pin_bad[i] == 0, "R9 cke/dqm high", pin_bad[i], 0);
  endtask

  initial begin
    vectors = 0;
    miscompares = 0;
    for (int i = 0; i < NI; i++) begin
      n_ev[i] = 0; rdy_cyc[i] = -1; pin_bad[i] = 0;
      cmd_after_rdy[i] = 0; rdy_drop[i] = 0;
    end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NI; i++) begin
      check(!cs_w[i] && ras_w[i] && cas_w[i] && we_w[i], "R1 idle in reset",
            int'({cs_w[i], ras_w[i], cas_w[i], we_w[i]}), 7);
      check(!rdy_w[i], "R1 ready low in reset", int'(rdy_w[i]), 0);
    end
    rst_n = 1'b1;
    begin : wait_ready
      for (int k = 0; k < 2000; k++) begin
        @(negedge clk);
        if (rdy_cyc[0] >= 0 && rdy_cyc[1] >= 0) disable wait_ready;
      end
      check(1'b0, "R8 watchdog expired", cyc, 0);
    end
    repeat (20) @(negedge clk);
    for (int i = 0; i < NI; i++) verify(i);
    // R1: asynchronous reset returns the bus to idle without a clock edge
    #1 rst_n = 1'b0;
    #0.5;
    for (int i = 0; i < NI; i++) begin
      check(!rdy_w[i], "R1 async reset clears ready", int'(rdy_w[i]), 0);
      check(!cs_w[i] && ras_w[i] && cas_w[i] && we_w[i], "R1 async reset idle",
            int'({cs_w[i], ras_w[i], cas_w[i], we_w[i]}), 7);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule